// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector

This block compares a divided reference square wave against a divided feedback square wave. It produces the error signal that drives a charge-pump style loop filter. Both inputs arrive from an unrelated timing domain. Each one passes through a multi-stage synchronizer, and only its rising edges are used. Two edge-triggered flags record which input edge came first. The block clears both flags in the cycle where both would be set. Pulse width therefore tracks the phase error in system clock cycles.

The error appears in two forms. The first is a single-ended three-state output, modelled as an enable plus a data bit. It drives high when the reference is ahead, drives low when the feedback is ahead, and floats when the two edges coincide. The second is a pair of active-low pulse outputs, one for each direction of correction. A lock indicator goes high after a run of comparisons with no wide pulses. It drops as soon as a pulse grows beyond a set tolerance.

Top module: `pfd_tristate`

## Requirements
- R1: After reset, err_oe is 0, up_n and dn_n are 1, and lock_det is 0.
- R2: When fb_in's rising edge trails ref_in's rising edge by d system clocks, the single-ended output drives high (err_oe=1, err_d=1) for exactly d cycles per comparison.
- R3: When fb_in's rising edge leads ref_in's rising edge by d system clocks, the single-ended output drives low (err_oe=1, err_d=0) for exactly d cycles per comparison.
- R4: When the two rising edges land in the same system clock, err_oe stays 0. The output is high impedance, and neither pulse output asserts.
- R5: When fb_in runs at a higher frequency than ref_in and its edges come first, only low drives appear on the single-ended output.
- R6: When fb_in runs at a lower frequency than ref_in and ref_in's edges come first, only high drives appear on the single-ended output.
- R7: up_n is 0 exactly while the single-ended output drives 1. dn_n is 0 exactly while it drives 0. The two are never 0 together.
- R8: lock_det rises only after LOCK_CYCLES consecutive comparisons in which no pulse lasted more than PULSE_TOL cycles.
- R9: A pulse longer than PULSE_TOL cycles clears lock_det one cycle after its (PULSE_TOL+1)-th cycle.
- R10: Pulses of at most PULSE_TOL cycles leave an established lock_det high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference signal, asynchronous |
| fb_in | input | 1 | Divided feedback signal, asynchronous |
| err_oe | output | 1 | Single-ended error output enable (0 means high impedance) |
| err_d | output | 1 | Single-ended error output data |
| up_n | output | 1 | Active-low pulse while the reference leads |
| dn_n | output | 1 | Active-low pulse while the feedback leads |
| lock_det | output | 1 | Phase coincidence indicator |

## Verification
The bench builds the block with SYNC_STAGES=3, PULSE_TOL=1, LOCK_CYCLES=3 and REG_OUTPUTS=1. This covers the longer synchronizer chain and the registered output variant. A lock threshold of three lets a lock be gained, held through one-cycle jitter pulses and lost, all within a few comparison periods. A tolerance of one separates a one-cycle pulse, which keeps lock, from a wider one, which drops it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef struct packed {
      logic oe;
      logic d;
      logic up_n;
      logic dn_n;
      logic lock;
   } pfd_out_t;

   localparam pfd_out_t PFD_OUT_IDLE = '{oe: 1'b0, d: 1'b0, up_n: 1'b1, dn_n: 1'b1, lock: 1'b0};

   function automatic pfd_out_t pfd_encode(input logic up, input logic dn, input logic lock);
      pfd_out_t o;
      o.oe   = up ^ dn;
      o.d    = up & ~dn;
      o.up_n = ~(up & ~dn);
      o.dn_n = ~(dn & ~up);
      o.lock = lock;
      return o;
   endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= sig_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_rise,
   input  logic fb_rise,
   output logic up,
   output logic dn,
   output logic cyc_end
);
   logic up_set, dn_set;

   always_comb begin
      up_set  = up | ref_rise;
      dn_set  = dn | fb_rise;
      cyc_end = up_set & dn_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else begin
         up <= up_set & ~cyc_end;
         dn <= dn_set & ~cyc_end;
      end
   end
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
   parameter int PULSE_TOL   = 1,
   parameter int LOCK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cyc_end,
   output logic lock
);
   localparam int WW = $clog2(PULSE_TOL + 2);
   localparam int GW = $clog2(LOCK_CYCLES + 1) + 1;
   localparam logic [WW-1:0] TOL_V  = WW'(PULSE_TOL);
   localparam logic [GW-1:0] NEED_V = GW'(LOCK_CYCLES);

   logic [WW-1:0] width_cnt;
   logic [GW-1:0] good_cnt;
   logic          wide;

   generate
      if (PULSE_TOL < 0) begin : g_bad_tol
         $error("pfd_lock: PULSE_TOL must not be negative");
      end
      if (LOCK_CYCLES < 1) begin : g_bad_need
         $error("pfd_lock: LOCK_CYCLES must be at least 1");
      end
   endgenerate

   assign wide = active && (width_cnt >= TOL_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_cnt <= '0;
      end else if (cyc_end) begin
         width_cnt <= '0;
      end else if (active && width_cnt != '1) begin
         width_cnt <= width_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         good_cnt <= '0;
         lock     <= 1'b0;
      end else if (wide) begin
         good_cnt <= '0;
         lock     <= 1'b0;
      end else if (cyc_end) begin
         if (good_cnt < NEED_V) good_cnt <= good_cnt + 1'b1;
         if (good_cnt + 1'b1 >= NEED_V) lock <= 1'b1;
      end
   end
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_TOL   = 1,
   parameter int LOCK_CYCLES = 4,
   parameter bit REG_OUTPUTS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic fb_in,
   output logic err_oe,
   output logic err_d,
   output logic up_n,
   output logic dn_n,
   output logic lock_det
);
   import pfd_pkg::*;

   logic     ref_rise, fb_rise;
   logic     up, dn, cyc_end;
   logic     lock_int;
   pfd_out_t raw, outs;

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_ref (
      .clk(clk), .rst_n(rst_n), .sig_in(ref_in), .rise(ref_rise));

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_fb (
      .clk(clk), .rst_n(rst_n), .sig_in(fb_in), .rise(fb_rise));

   pfd_flags i_flags (
      .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
      .up(up), .dn(dn), .cyc_end(cyc_end));

   pfd_lock #(.PULSE_TOL(PULSE_TOL), .LOCK_CYCLES(LOCK_CYCLES)) i_lock (
      .clk(clk), .rst_n(rst_n), .active(up ^ dn), .cyc_end(cyc_end),
      .lock(lock_int));

   assign raw = pfd_encode(up, dn, lock_int);

   generate
      if (REG_OUTPUTS) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) outs <= PFD_OUT_IDLE;
            else        outs <= raw;
         end
      end else begin : g_out_comb
         assign outs = raw;
      end
   endgenerate

   assign err_oe   = outs.oe;
   assign err_d    = outs.d;
   assign up_n     = outs.up_n;
   assign dn_n     = outs.dn_n;
   assign lock_det = outs.lock;
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk #(
   parameter int PULSE_TOL = 1
) (
   input logic clk,
   input logic rst_n,
   input logic err_oe,
   input logic err_d,
   input logic up_n,
   input logic dn_n,
   input logic lock_det
);
   int unsigned run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                     run_cnt <= 0;
      else if (!err_oe)               run_cnt <= 0;
      else if (run_cnt != 32'hFFFF_FFFF) run_cnt <= run_cnt + 1;
   end

   assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~up_n, ~dn_n}));

   assert_enable_tracks_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_oe == (!up_n || !dn_n));

   assert_up_drives_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !up_n |-> (err_oe && err_d));

   assert_dn_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dn_n |-> (err_oe && !err_d));

   assert_wide_pulse_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_oe && run_cnt >= PULSE_TOL) |=> !lock_det);
endmodule

bind pfd_tristate pfd_tristate_chk #(.PULSE_TOL(PULSE_TOL)) i_pfd_chk (
   .clk(clk), .rst_n(rst_n), .err_oe(err_oe), .err_d(err_d),
   .up_n(up_n), .dn_n(dn_n), .lock_det(lock_det));

// File: tb/test_pfd_tristate.sv
module test_pfd_tristate;
   localparam int SYNC_STAGES = 3;
   localparam int PULSE_TOL   = 1;
   localparam int LOCK_CYCLES = 3;
   localparam int MAX_CYCLES  = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_in = 1'b0;
   logic fb_in = 1'b0;
   logic err_oe, err_d, up_n, dn_n, lock_det;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int ups, dns, bad7;

   pfd_tristate #(.SYNC_STAGES(SYNC_STAGES), .PULSE_TOL(PULSE_TOL),
                  .LOCK_CYCLES(LOCK_CYCLES), .REG_OUTPUTS(1'b1)) i_pfd_tristate (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .err_oe(err_oe), .err_d(err_d), .up_n(up_n), .dn_n(dn_n), .lock_det(lock_det));

   always #10ns clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == MAX_CYCLES) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<%0d", cycles, MAX_CYCLES);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic wave(input int i, input int p, input int off);
      return (i >= off) && (((i - off) % p) < p / 2);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_waves(input int pr, input int offr, input int pv, input int offv, input int n);
      ups = 0; dns = 0; bad7 = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (err_oe && err_d)  ups++;
         if (err_oe && !err_d) dns++;
         if (up_n !== !(err_oe && err_d) || dn_n !== !(err_oe && !err_d)) bad7++;
         ref_in = wave(i, pr, offr);
         fb_in  = wave(i, pv, offv);
      end
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check(err_oe == 1'b0, "R1 err_oe", err_oe, 0);
      check(up_n == 1'b1, "R1 up_n", up_n, 1);
      check(dn_n == 1'b1, "R1 dn_n", dn_n, 1);
      check(lock_det == 1'b0, "R1 lock_det", lock_det, 0);
   endtask

   task automatic t_fb_lags(input int d);
      do_reset();
      run_waves(40, 0, 40, d, 80);
      check(ups == 2 * d, "R2 high drive cycles", ups, 2 * d);
      check(dns == 0, "R2 no low drive", dns, 0);
      check(bad7 == 0, "R7 pulse outputs vs single-ended", bad7, 0);
   endtask

   task automatic t_fb_leads(input int d);
      do_reset();
      run_waves(40, d, 40, 0, 80);
      check(dns == 2 * d, "R3 low drive cycles", dns, 2 * d);
      check(ups == 0, "R3 no high drive", ups, 0);
      check(bad7 == 0, "R7 pulse outputs vs single-ended", bad7, 0);
   endtask

   task automatic t_coincident();
      do_reset();
      run_waves(40, 0, 40, 0, 120);
      check(ups + dns == 0, "R4 output stays high impedance", ups + dns, 0);
      check(bad7 == 0, "R4 pulse outputs idle", bad7, 0);
   endtask

   task automatic t_fb_faster();
      do_reset();
      run_waves(40, 5, 24, 0, 240);
      check(ups == 0, "R5 no high drive with faster feedback", ups, 0);
      check(dns > 0, "R5 low drives present", dns, 1);
      check(bad7 == 0, "R7 pulse outputs vs single-ended", bad7, 0);
   endtask

   task automatic t_fb_slower();
      do_reset();
      run_waves(24, 0, 40, 5, 240);
      check(dns == 0, "R6 no low drive with slower feedback", dns, 0);
      check(ups > 0, "R6 high drives present", ups, 1);
      check(bad7 == 0, "R7 pulse outputs vs single-ended", bad7, 0);
   endtask

   task automatic t_lock();
      do_reset();
      run_waves(40, 0, 40, 0, 70);
      check(lock_det == 1'b0, "R8 no lock before LOCK_CYCLES comparisons", lock_det, 0);
      run_waves(40, 0, 40, 0, 200);
      check(lock_det == 1'b1, "R8 lock after clean comparisons", lock_det, 1);
      run_waves(40, 0, 40, 1, 200);
      check(ups == 5, "R10 one-cycle pulses seen", ups, 5);
      check(lock_det == 1'b1, "R10 lock held through one-cycle pulses", lock_det, 1);
      run_waves(40, 0, 40, 4, 80);
      check(ups == 8, "R9 wide pulses seen", ups, 8);
      check(lock_det == 1'b0, "R9 lock lost after wide pulse", lock_det, 0);
   endtask

   initial begin
      t_reset();
      t_fb_lags(3);
      t_fb_lags(7);
      t_fb_leads(2);
      t_fb_leads(6);
      t_coincident();
      t_fb_faster();
      t_fb_slower();
      t_lock();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule